// File: doc/BRIEF.md
# Serial-Programmed Stereo Output Processor

This block takes 16-bit control words over a three-wire serial port (shift clock, data, latch) and decodes them into four configuration registers. Two bits inside each word pick the register, so one port programs everything. The decoded settings are applied to every stereo sample pair that arrives with a valid strobe. Each output lane picks its source: silence, left, right, or the floored average of both. The lane then scales the sample by an 8-bit attenuation step and passes through a soft-mute ramp. The output can also be forced to bipolar zero (code 0) by a disable bit, by zero detection, or by an external reset.

The format-selection fields (serial format, word-clock polarity, word length) and the 2-bit de-emphasis selection are stored and exported to neighbouring logic. De-emphasis filtering itself is not done here. Each processed pair is registered and appears one system-clock cycle after its strobe.

Top module: `ctl_chan_proc`

## Requirements
- R1: A control word is shifted in MSB first on rising edges of `ctl_clk_i`. It is committed on a high-to-low transition of `ctl_lat_n_i`. Word bits 10:9 select the register (0 left attenuation, 1 right attenuation, 2 mute/de-emphasis/disable/zero-detect, 3 format/mapping). Bits 15:11 are ignored.
- R2: During the first 1,024 system-clock cycles after `rst_ni` is released, committed words are ignored.
- R3: A lane with effective step x scales its source by y/256, rounded toward minus infinity. y equals x for x in 0..254, and y is 256 for x = 255. Step 0 gives 0 and step 255 passes the sample unchanged.
- R4: Registers 0 and 1 hold a step in bits 7:0 and a load flag in bit 8. A write with load 1 makes that register's new step and the other register's last stored step active on both channels at once. A write with load 0 only stores the step, and the active levels stay as they were.
- R5: Register 2 holds soft mute in bit 0, de-emphasis select in bits 2:1 (exported on `deemph_sel_o` with bit 1 as its LSB), output-disable in bit 3 and zero-detect enable in bit 4. Register 3 bits 0, 1 and 2 drive `fmt_i2s_o`, `fmt_lr_inv_o` and `fmt_w18_o`.
- R6: Register 3 bits {4,5} form the left-lane source code and bits {6,7} form the right-lane source code. In each pair the lower-numbered bit is the MSB. The codes are 00 silence, 01 right input, 10 left input, 11 average. A sample produces `out_valid_o` and the result one cycle after `smp_valid_i`, and the outputs hold between samples.
- R7: The average source is floor((L+R)/2), computed without overflow.
- R8: When register 3 bit 3 is 1, the right lane uses the left active step, and the right active step is not used.
- R9: The step used for a sample is min(ramp state, active step). After each sample with mute set, the ramp state becomes that step minus one, floored at 0. After each sample without mute, it becomes that step plus one, capped at the active step.
- R10: While output-disable is 1, both outputs of each sample are 0.
- R11: While zero-detect is enabled and `zero_run_i` is high with the sample, both outputs are 0. With zero-detect disabled, `zero_run_i` has no effect.
- R12: While `ext_rst_ni` is low, both outputs are 0 and committed words are ignored.
- R13: After `rst_ni`, all register fields are 0 and both attenuation steps (stored, active and ramp state) are 255. With all fields at 0, both source codes are 00, so every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_ni | input | 1 | External reset, active low: forces zero output and blocks writes |
| ctl_clk_i | input | 1 | Serial control shift clock |
| ctl_dat_i | input | 1 | Serial control data |
| ctl_lat_n_i | input | 1 | Serial control latch; a falling edge commits the word |
| smp_valid_i | input | 1 | Sample pair strobe |
| smp_l_i | input | 18 | Left input sample, two's complement |
| smp_r_i | input | 18 | Right input sample, two's complement |
| zero_run_i | input | 1 | Zero-run flag from the input stage |
| out_valid_o | output | 1 | Output pair strobe |
| out_l_o | output | 18 | Left processed sample |
| out_r_o | output | 18 | Right processed sample |
| fmt_i2s_o | output | 1 | Serial format select |
| fmt_lr_inv_o | output | 1 | Word-clock polarity invert |
| fmt_w18_o | output | 1 | 18-bit word length select |
| deemph_sel_o | output | 2 | De-emphasis selection |

## Verification
The bench first writes during the power-up lockout. A design without the lockout would take that word and pass samples through instead of holding silence. It then tests the attenuation law at steps 254, 128, 0 and 255, using negative odd products. A design that gets the top-step exception or the rounding wrong would be off by one code or scale by 255/256. It checks the load-flag pairing: a load-0 write must change nothing, and a later load-1 write must bring in the other channel's stored step. It also checks the mute ramp down and back up at a small step, and the average of a negative odd sum, where a truncating design rounds toward zero. Finally it checks forcing by disable, zero detect and external reset, and that writes made during external reset are lost.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int WORD_W = 16;
  localparam int STEP_W = 8;
  localparam int ADDR_LO = 9;
  localparam int LOAD_BIT = 8;

  localparam logic [1:0] REG_ATT_L = 2'd0;
  localparam logic [1:0] REG_ATT_R = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;
  localparam logic [1:0] REG_FMT   = 2'd3;

  localparam logic [1:0] SRC_MUTE = 2'b00;
  localparam logic [1:0] SRC_R    = 2'b01;
  localparam logic [1:0] SRC_L    = 2'b10;

  typedef struct packed {
    logic              mute;
    logic [1:0]        deemph;
    logic              out_dis;
    logic              zdet_en;
    logic              i2s;
    logic              lr_inv;
    logic              w18;
    logic              mono_att;
    logic [1:0]        src_l;
    logic [1:0]        src_r;
    logic [STEP_W-1:0] act_l;
    logic [STEP_W-1:0] act_r;
  } cfg_t;
endpackage

// File: rtl/ctl_shift.sv
module ctl_shift
  import ccp_pkg::*;
#(
  parameter int LOCK_CYC = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              slat_ni,
  output logic              ready_o,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LOCK_V = CW'(LOCK_CYC);

  logic [CW-1:0]     cnt_q;
  logic              sclk_q, sclk_qq, sdat_q, slat_q, slat_qq;
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      sdat_q  <= 1'b0;
      slat_q  <= 1'b1;
      slat_qq <= 1'b1;
      sh_q    <= '0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_qq <= sclk_q;
      sdat_q  <= sdat_i;
      slat_q  <= slat_ni;
      slat_qq <= slat_q;
      if (cnt_q != LOCK_V) cnt_q <= cnt_q + 1'b1;
      if (en_i && sclk_q && !sclk_qq) sh_q <= {sh_q[WORD_W-2:0], sdat_q};
    end
  end

  assign ready_o  = (cnt_q == LOCK_V);
  assign commit_o = ready_o && en_i && slat_qq && !slat_q;
  assign word_o   = sh_q;

  // lockout, once over, never returns
  p_lock_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import ccp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output cfg_t              cfg_o
);
  logic [STEP_W-1:0] pend_l_q, pend_r_q;
  cfg_t              cfg_q;
  logic [1:0]        addr;
  logic              load;

  assign addr = word_i[ADDR_LO +: 2];
  assign load = word_i[LOAD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q       <= '0;
      cfg_q.act_l <= '1;
      cfg_q.act_r <= '1;
      pend_l_q    <= '1;
      pend_r_q    <= '1;
    end else if (commit_i) begin
      unique case (addr)
        REG_ATT_L: begin
          pend_l_q <= word_i[STEP_W-1:0];
          if (load) begin
            cfg_q.act_l <= word_i[STEP_W-1:0];
            cfg_q.act_r <= pend_r_q;
          end
        end
        REG_ATT_R: begin
          pend_r_q <= word_i[STEP_W-1:0];
          if (load) begin
            cfg_q.act_r <= word_i[STEP_W-1:0];
            cfg_q.act_l <= pend_l_q;
          end
        end
        REG_CTRL: begin
          cfg_q.mute    <= word_i[0];
          cfg_q.deemph  <= word_i[2:1];
          cfg_q.out_dis <= word_i[3];
          cfg_q.zdet_en <= word_i[4];
        end
        default: begin
          cfg_q.i2s      <= word_i[0];
          cfg_q.lr_inv   <= word_i[1];
          cfg_q.w18      <= word_i[2];
          cfg_q.mono_att <= word_i[3];
          cfg_q.src_l    <= {word_i[4], word_i[5]};
          cfg_q.src_r    <= {word_i[6], word_i[7]};
        end
      endcase
    end
  end

  assign cfg_o = cfg_q;

  p_noload_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !load && (addr == REG_ATT_L || addr == REG_ATT_R))
      |=> ($stable(cfg_o.act_l) && $stable(cfg_o.act_r)));
endmodule

// File: rtl/chan_lane.sv
module chan_lane
  import ccp_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     smp_valid_i,
  input  logic signed [DW-1:0]     l_i,
  input  logic signed [DW-1:0]     r_i,
  input  logic signed [DW-1:0]     mix_i,
  input  logic [1:0]               sel_i,
  input  logic [STEP_W-1:0]        target_i,
  input  logic                     mute_i,
  output logic signed [DW-1:0]     y_o
);
  localparam int PW = DW + STEP_W + 2;

  logic [STEP_W-1:0]   eff_q, cur;
  logic [STEP_W:0]     mul;
  logic signed [DW-1:0] src;
  logic signed [PW-1:0] prod, shf;

  always_comb cur = (eff_q > target_i) ? target_i : eff_q;

  always_comb begin
    unique case (sel_i)
      SRC_MUTE: src = '0;
      SRC_R:    src = r_i;
      SRC_L:    src = l_i;
      default:  src = mix_i;
    endcase
  end

  // top step stands for a gain of exactly one
  assign mul  = (&cur) ? {1'b1, {STEP_W{1'b0}}} : {1'b0, cur};
  assign prod = $signed(PW'(src)) * $signed(PW'(mul));
  assign shf  = prod >>> STEP_W;
  assign y_o  = shf[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_q <= '1;
    else if (smp_valid_i) begin
      if (mute_i)               eff_q <= (cur == '0) ? '0 : cur - 1'b1;
      else if (cur < target_i)  eff_q <= cur + 1'b1;
      else                      eff_q <= cur;
    end
  end

  p_mute_nonrise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_i |=> eff_q <= $past(eff_q));
endmodule

// File: rtl/ctl_chan_proc.sv
module ctl_chan_proc
  import ccp_pkg::*;
#(
  parameter int DW       = 18,
  parameter int LOCK_CYC = 1024
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_rst_ni,
  input  logic          ctl_clk_i,
  input  logic          ctl_dat_i,
  input  logic          ctl_lat_n_i,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_l_i,
  input  logic [DW-1:0] smp_r_i,
  input  logic          zero_run_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_l_o,
  output logic [DW-1:0] out_r_o,
  output logic          fmt_i2s_o,
  output logic          fmt_lr_inv_o,
  output logic          fmt_w18_o,
  output logic [1:0]    deemph_sel_o
);
  localparam int NCH = 2;

  logic              ready, commit;
  logic [WORD_W-1:0] word;
  cfg_t              cfg;
  logic signed [DW:0]   sum;
  logic signed [DW-1:0] mix;
  logic signed [DW-1:0] y   [NCH];
  logic [1:0]           sel [NCH];
  logic [STEP_W-1:0]    tgt [NCH];
  logic                 force_zero;

  ctl_shift #(.LOCK_CYC(LOCK_CYC)) u_shift (
    .clk_i, .rst_ni, .en_i(ext_rst_ni),
    .sclk_i(ctl_clk_i), .sdat_i(ctl_dat_i), .slat_ni(ctl_lat_n_i),
    .ready_o(ready), .commit_o(commit), .word_o(word)
  );

  ctl_regs u_regs (
    .clk_i, .rst_ni, .commit_i(commit), .word_i(word), .cfg_o(cfg)
  );

  assign sum = {smp_l_i[DW-1], smp_l_i} + {smp_r_i[DW-1], smp_r_i};
  assign mix = sum[DW:1];

  assign sel[0] = cfg.src_l;
  assign sel[1] = cfg.src_r;
  assign tgt[0] = cfg.act_l;
  assign tgt[1] = cfg.mono_att ? cfg.act_l : cfg.act_r;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    chan_lane #(.DW(DW)) u_lane (
      .clk_i, .rst_ni, .smp_valid_i,
      .l_i(smp_l_i), .r_i(smp_r_i), .mix_i(mix),
      .sel_i(sel[c]), .target_i(tgt[c]), .mute_i(cfg.mute), .y_o(y[c])
    );
  end

  assign force_zero = !ext_rst_ni || cfg.out_dis || (cfg.zdet_en && zero_run_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_l_o     <= '0;
      out_r_o     <= '0;
    end else begin
      out_valid_o <= smp_valid_i;
      if (smp_valid_i) begin
        out_l_o <= force_zero ? '0 : y[0];
        out_r_o <= force_zero ? '0 : y[1];
      end
    end
  end

  assign fmt_i2s_o    = cfg.i2s;
  assign fmt_lr_inv_o = cfg.lr_inv;
  assign fmt_w18_o    = cfg.w18;
  assign deemph_sel_o = cfg.deemph;

  p_lock_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> $stable(cfg));
  p_ext_cfg_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> $stable(cfg));
  p_ext_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !ext_rst_ni) |=> (out_l_o == '0 && out_r_o == '0));
  p_dis_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && cfg.out_dis) |=> (out_l_o == '0 && out_r_o == '0));
  p_zdet_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && cfg.zdet_en && zero_run_i) |=> (out_l_o == '0 && out_r_o == '0));
  p_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> out_valid_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(out_l_o) && $stable(out_r_o)));
endmodule

// File: tb/ctl_chan_proc_test.sv
module ctl_chan_proc_test;
  localparam int CLK_P = 10;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, ext_rst_ni = 1'b1;
  logic ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_lat_n = 1'b1;
  logic smp_valid = 1'b0, zero_run = 1'b0;
  logic [DW-1:0] smp_l = '0, smp_r = '0;
  logic out_valid_o, fmt_i2s_o, fmt_lr_inv_o, fmt_w18_o;
  logic [DW-1:0] out_l_o, out_r_o;
  logic [1:0] deemph_sel_o;

  always #(CLK_P/2) clk = ~clk;

  ctl_chan_proc uut (
    .clk_i(clk), .rst_ni, .ext_rst_ni, .ctl_clk_i(ctl_clk), .ctl_dat_i(ctl_dat),
    .ctl_lat_n_i(ctl_lat_n), .smp_valid_i(smp_valid), .smp_l_i(smp_l), .smp_r_i(smp_r),
    .zero_run_i(zero_run), .out_valid_o, .out_l_o, .out_r_o, .fmt_i2s_o,
    .fmt_lr_inv_o, .fmt_w18_o, .deemph_sel_o
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side model of the programmed state
  bit m_mute, m_dis, m_zdet, m_mono, m_i2s, m_inv, m_w18;
  int m_deemph, m_srcl, m_srcr;
  int m_actl = 255, m_actr = 255, m_pendl = 255, m_pendr = 255;
  int m_effl = 255, m_effr = 255;

  int q_l[$];
  int q_r[$];
  string q_tag[$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_word(logic [15:0] w);
    case (w[10:9])
      2'd0: begin
        m_pendl = int'(w[7:0]);
        if (w[8]) begin m_actl = int'(w[7:0]); m_actr = m_pendr; end
      end
      2'd1: begin
        m_pendr = int'(w[7:0]);
        if (w[8]) begin m_actr = int'(w[7:0]); m_actl = m_pendl; end
      end
      2'd2: begin
        m_mute = w[0]; m_deemph = int'(w[2:1]); m_dis = w[3]; m_zdet = w[4];
      end
      default: begin
        m_i2s = w[0]; m_inv = w[1]; m_w18 = w[2]; m_mono = w[3];
        m_srcl = {30'd0, w[4], w[5]};
        m_srcr = {30'd0, w[6], w[7]};
      end
    endcase
  endtask

  task automatic write_word(logic [15:0] w, bit accept);
    for (int i = 15; i >= 0; i--) begin
      ctl_dat = w[i];
      repeat (2) @(negedge clk);
      ctl_clk = 1'b1;
      repeat (2) @(negedge clk);
      ctl_clk = 1'b0;
    end
    repeat (2) @(negedge clk);
    ctl_lat_n = 1'b0;
    repeat (3) @(negedge clk);
    ctl_lat_n = 1'b1;
    repeat (3) @(negedge clk);
    if (accept) apply_word(w);
  endtask

  function automatic int pick(int sel, int l, int r);
    case (sel)
      0: return 0;
      1: return r;
      2: return l;
      default: return (l + r) >>> 1;  // R7 floor average
    endcase
  endfunction

  function automatic int gain(int v, int step);
    int y = (step == 255) ? 256 : step;  // R3 law
    return (v * y) >>> 8;
  endfunction

  function automatic int next_eff(int cur, int tgt);
    if (m_mute) return (cur == 0) ? 0 : cur - 1;  // R9
    return (cur < tgt) ? cur + 1 : cur;
  endfunction

  task automatic send(int l, int r, bit zr, string tag);
    int tl, tr, cl, cr, el, er;
    bit fz;
    tl = m_actl;
    tr = m_mono ? m_actl : m_actr;  // R8
    cl = (m_effl > tl) ? tl : m_effl;
    cr = (m_effr > tr) ? tr : m_effr;
    el = gain(pick(m_srcl, l, r), cl);
    er = gain(pick(m_srcr, l, r), cr);
    fz = !ext_rst_ni || m_dis || (m_zdet && zr);
    if (fz) begin el = 0; er = 0; end
    q_l.push_back(el); q_r.push_back(er); q_tag.push_back(tag);
    m_effl = next_eff(cl, tl);
    m_effr = next_eff(cr, tr);
    smp_l = l[DW-1:0]; smp_r = r[DW-1:0]; zero_run = zr; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; zero_run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (out_valid_o) begin
      if (q_l.size() == 0) check(1'b0, "R6 unexpected output", 1, 0);
      else begin
        int el, er, al, ar;
        string t;
        el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
        al = int'($signed(out_l_o)); ar = int'($signed(out_r_o));
        check(al == el, {t, " left"}, al, el);
        check(ar == er, {t, " right"}, ar, er);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(out_valid_o == 1'b0, "R13 valid", int'(out_valid_o), 0);
    check(out_l_o == '0 && out_r_o == '0, "R13 data", int'(out_l_o), 0);
    check({fmt_i2s_o, fmt_lr_inv_o, fmt_w18_o, deemph_sel_o} == 5'd0, "R13 fmt",
          int'({fmt_i2s_o, fmt_lr_inv_o, fmt_w18_o, deemph_sel_o}), 0);
    send(1000, -500, 0, "R13 default silent");

    // R2 write during lockout is ignored
    write_word(16'h0697, 1'b0);
    send(1000, -500, 0, "R2 lockout");
    check(fmt_i2s_o == 1'b0, "R2 fmt", int'(fmt_i2s_o), 0);

    repeat (1100) @(negedge clk);
    // R1 R6 stereo straight
    write_word(16'h0690, 1'b1);
    send(1000, -500, 0, "R6 stereo");
    send(-131072, 131071, 0, "R1 full scale");
    // R6 swapped
    write_word(16'h0660, 1'b1);
    send(123, -77, 0, "R6 swap");
    // R7 average
    write_word(16'h06F0, 1'b1);
    send(3, -6, 0, "R7 odd negative");
    send(131071, 131071, 0, "R7 no overflow");
    // R6 left only, right silent
    write_word(16'h0610, 1'b1);
    send(500, 500, 0, "R6 left mute");
    write_word(16'h0690, 1'b1);

    // R3 attenuation law
    write_word(16'h01FE, 1'b1);
    send(1000, 1000, 0, "R3 step 254");
    write_word(16'h0180, 1'b1);
    send(1000, 1000, 0, "R3 step 128");
    send(-1001, 7, 0, "R3 floor");
    // R8 mono attenuation
    write_word(16'h0698, 1'b1);
    send(1000, 1000, 0, "R8 mono att");
    write_word(16'h0690, 1'b1);
    // R4 load flag
    write_word(16'h0240, 1'b1);
    send(1000, 1000, 0, "R4 no load");
    write_word(16'h0180, 1'b1);
    send(1000, 1000, 0, "R4 paired load");
    write_word(16'h0300, 1'b1);
    send(1000, 1000, 0, "R3 step 0");

    // R9 mute ramp at step 3
    write_word(16'h0103, 1'b1);
    write_word(16'h0303, 1'b1);
    for (int i = 0; i < 4; i++) send(10000, 10000, 0, "R9 settle");
    write_word(16'h0401, 1'b1);
    for (int i = 0; i < 5; i++) send(10000, -10000, 0, "R9 ramp down");
    write_word(16'h0400, 1'b1);
    for (int i = 0; i < 5; i++) send(10000, -10000, 0, "R9 ramp up");

    // R5 field decode
    write_word(16'h0406, 1'b1);
    check(deemph_sel_o == 2'd3, "R5 deemph 3", int'(deemph_sel_o), 3);
    write_word(16'h0402, 1'b1);
    check(deemph_sel_o == 2'd1, "R5 deemph lsb", int'(deemph_sel_o), 1);
    write_word(16'h0697, 1'b1);
    check({fmt_i2s_o, fmt_lr_inv_o, fmt_w18_o} == 3'b111, "R5 fmt bits",
          int'({fmt_i2s_o, fmt_lr_inv_o, fmt_w18_o}), 7);
    write_word(16'h0690, 1'b1);
    check(fmt_i2s_o == 1'b0, "R5 fmt clear", int'(fmt_i2s_o), 0);

    // R10 disable
    write_word(16'h0408, 1'b1);
    send(1000, -1000, 0, "R10 disable");
    // R11 zero detect
    write_word(16'h0410, 1'b1);
    send(1000, -1000, 1, "R11 zero run");
    send(1000, -1000, 0, "R11 no run");
    write_word(16'h0400, 1'b1);
    send(1000, -1000, 1, "R11 detect off");

    // R12 external reset
    ext_rst_ni = 1'b0;
    @(negedge clk);
    write_word(16'h0691, 1'b0);
    send(1000, -1000, 0, "R12 forced");
    check(fmt_i2s_o == 1'b0, "R12 write ignored", int'(fmt_i2s_o), 0);
    ext_rst_ni = 1'b1;
    @(negedge clk);
    send(1000, -1000, 0, "R12 released");

    repeat (5) @(negedge clk);
    check(q_l.size() == 0, "R6 drained", q_l.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule